// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters into a serial bit stream. A host writes a character into a one-entry holding register; when the shift stage is free and the line is allowed to send, the character moves into the shift stage and the holding register is free for the next write. Because of this, characters can go out back to back with no idle gap between them.

The line is paced by an external transmit clock. That clock is sampled in the system clock domain, and the serial output moves only after a falling edge of it. In asynchronous mode each character is framed with a start bit, the data, an optional parity bit and one, one-and-a-half or two stop bits. Each bit lasts 1, 16 or 64 transmit-clock periods. In synchronous mode characters are sent raw. When the holding register runs dry, the programmed sync character or characters fill the line. Sending is gated by a transmit enable and an active-low clear-to-send input, and a break input forces the line low.

Top module: `dbuf_serial_tx`

## Requirements
- R1: `txrdy_stat_o` is high exactly when the holding register is empty. `txrdy_o` is high only when the register is empty, `tx_en_i` is 1 and `cts_ni` is 0. A one-cycle `wr_i` pulse drives both low from the next cycle.
- R2: `txd_o` is high after reset and whenever nothing is being shifted. While `break_i` is 1, `txd_o` is low in the same cycle.
- R3: `txempty_o` is high when the holding register is empty and no character is being shifted, and it goes low the cycle after a write. In synchronous mode it is also high while sync characters are being sent.
- R4: In synchronous mode, if the holding register is empty when a character ends, sync characters follow with no gap. With `sync_dual_i`=0, character 1 repeats. With `sync_dual_i`=1, the order is character 1, then character 2, then character 1, and so on. Sync fill never starts while a character is waiting.
- R5: Clearing `tx_en_i` or raising `cts_ni` in the middle of a character does not cut it short. After it ends, `txd_o` and `txempty_o` are high.
- R6: A character written while sending is gated stays in the holding register and never appears on `txd_o`. It is sent once sending is allowed again.
- R7: `txd_o` changes only a few system clocks after a falling edge of `txc_i`. In asynchronous mode `baud_sel_i` sets the bit length in transmit-clock periods: 2'b10 gives 16, 2'b11 gives 64, and 2'b01 or 2'b00 give 1.
- R8: An asynchronous frame is a low start bit, then the data bits, then the parity bit if enabled, then high stop bits. `stop_sel_i` sets the stop length: 2'b10 gives 1.5 bits (2 bits at factor 1), 2'b11 gives 2 bits, and 2'b01 or 2'b00 give 1 bit.
- R9: Data goes out least significant bit first. `char_len_i` values 0 to 3 select 5 to 8 bits, and bits above that length are ignored. With even parity (`parity_even_i`=1) the parity bit is the XOR of the data bits; with odd parity it is the inverse.
- R10: In synchronous mode a character is just its data bits plus parity if enabled, one bit per transmit-clock period, with no start or stop bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txc_i | input | 1 | Transmit clock; the line moves after each falling edge |
| sync_mode_i | input | 1 | 1 selects synchronous mode |
| char_len_i | input | 2 | Character length select, 0..3 gives 5..8 bits |
| parity_en_i | input | 1 | Adds a parity bit |
| parity_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| stop_sel_i | input | 2 | Stop length select (asynchronous mode) |
| baud_sel_i | input | 2 | Bit length factor select (asynchronous mode) |
| sync_dual_i | input | 1 | 1 makes sync fill alternate between two characters |
| sync_char1_i | input | 8 | First sync character |
| sync_char2_i | input | 8 | Second sync character |
| tx_en_i | input | 1 | Transmit enable |
| cts_ni | input | 1 | Clear to send, active low |
| break_i | input | 1 | Forces the line low |
| wr_i | input | 1 | One-cycle data write strobe |
| wr_data_i | input | 8 | Character to write |
| txd_o | output | 1 | Serial output |
| txrdy_o | output | 1 | Ready to accept a character, gated by enable and clear-to-send |
| txrdy_stat_o | output | 1 | Holding register empty, not gated |
| txempty_o | output | 1 | No character left to send |

## Verification
Some properties are checked on every cycle. A write clears both ready flags and the empty flag on the next cycle. A character held while sending is gated stays in the holding register. The line moves only after a detected falling edge of the transmit clock. The per-bit counter stays within the current bit length. Sync fill begins only when the holding register is empty.

Other behaviour can only be shown by the bench scenarios. These cover the bit order, the masking of upper bits, and the parity value. They cover the exact length of frames with each stop length and each factor, measured as the time from one start bit to the next. They also cover the order of sync characters in the stream, and a character written while gated or cut off mid-frame still arriving intact.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
  localparam int DATA_W     = 8;
  localparam int MID_FACTOR = 16;
  localparam int MAX_FACTOR = 64;
  localparam int CNT_W      = $clog2(MAX_FACTOR) + 1;
  localparam int FRAME_W    = DATA_W + 4;             // start + data + parity + two stops
  localparam int NB_W       = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [FRAME_W-1:0] bits;       // bit 0 leaves first
    logic [NB_W-1:0]    nbits;
    logic [CNT_W-1:0]   slot_len;   // falling edges per bit
    logic               half_last;  // last stop bit is half length
  } frame_t;
endpackage

// File: rtl/dbtx_clk_edge.sv
module dbtx_clk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txc_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], txc_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/dbtx_framer.sv
module dbtx_framer
  import dbtx_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        char_len_i,
  input  logic              parity_en_i,
  input  logic              parity_even_i,
  input  logic              sync_mode_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        baud_sel_i,
  output frame_t            frame_o
);
  logic [DATA_W-1:0]  mask, masked;
  logic               par;
  logic [FRAME_W-1:0] word;
  int                 nd, off, pos, nstop;

  always_comb begin
    nd = 5 + int'(char_len_i);
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < nd);
    masked = data_i & mask;
    par    = parity_even_i ? ^masked : ~(^masked);
    off    = sync_mode_i ? 0 : 1;
    word   = '1;
    word   = word & ~(FRAME_W'(mask) << off);
    word   = word | (FRAME_W'(masked) << off);
    if (!sync_mode_i) word[0] = 1'b0;
    pos = off + nd;
    if (parity_en_i) begin
      word = word & ~(FRAME_W'(1) << pos);
      word = word | (FRAME_W'(par) << pos);
      pos  = pos + 1;
    end
    nstop = sync_mode_i ? 0 : (stop_sel_i[1] ? 2 : 1);
    frame_o.bits      = word;
    frame_o.nbits     = NB_W'(pos + nstop);
    frame_o.half_last = !sync_mode_i && (stop_sel_i == 2'b10);
    if (sync_mode_i)              frame_o.slot_len = CNT_W'(1);
    else if (baud_sel_i == 2'b10) frame_o.slot_len = CNT_W'(MID_FACTOR);
    else if (baud_sel_i == 2'b11) frame_o.slot_len = CNT_W'(MAX_FACTOR);
    else                          frame_o.slot_len = CNT_W'(1);
  end
endmodule

// File: rtl/dbtx_engine.sv
module dbtx_engine
  import dbtx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fall_i,
  input  logic   enable_i,
  input  logic   sync_mode_i,
  input  logic   sync_dual_i,
  input  logic   hold_full_i,
  input  frame_t data_frame_i,
  input  frame_t sync_frame_i,
  output logic   load_o,
  output logic   line_o,
  output logic   busy_o,
  output logic   filling_o,
  output logic   sync_sel_o
);
  logic               busy_q, half_q, filling_q, run_q, sel_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [NB_W-1:0]    left_q;
  logic [CNT_W-1:0]   cnt_q, len_q, half_len, cur_len;
  logic               slot_end, free, go_data, go_sync;

  always_comb begin
    half_len = len_q >> 1;
    if (half_len == '0) half_len = CNT_W'(1);
    cur_len  = (half_q && left_q == '0) ? half_len : len_q;
  end

  assign slot_end = busy_q && (cnt_q == cur_len - CNT_W'(1));
  assign free     = !busy_q || (slot_end && left_q == '0);
  assign go_data  = fall_i && free && enable_i && hold_full_i;
  assign go_sync  = fall_i && free && enable_i && !hold_full_i && sync_mode_i && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      shreg_q   <= '1;
      left_q    <= '0;
      cnt_q     <= '0;
      len_q     <= CNT_W'(1);
      half_q    <= 1'b0;
      filling_q <= 1'b0;
      run_q     <= 1'b0;
      sel_q     <= 1'b0;
    end else if (fall_i) begin
      if (go_data) begin
        shreg_q   <= data_frame_i.bits;
        left_q    <= data_frame_i.nbits - NB_W'(1);
        len_q     <= data_frame_i.slot_len;
        half_q    <= data_frame_i.half_last;
        cnt_q     <= '0;
        busy_q    <= 1'b1;
        filling_q <= 1'b0;
        run_q     <= sync_mode_i;
        sel_q     <= 1'b0;
      end else if (go_sync) begin
        shreg_q   <= sync_frame_i.bits;
        left_q    <= sync_frame_i.nbits - NB_W'(1);
        len_q     <= sync_frame_i.slot_len;
        half_q    <= 1'b0;
        cnt_q     <= '0;
        busy_q    <= 1'b1;
        filling_q <= 1'b1;
        sel_q     <= sync_dual_i ? ~sel_q : 1'b0;
      end else if (free) begin
        busy_q    <= 1'b0;
        filling_q <= 1'b0;
        run_q     <= 1'b0;
      end else if (slot_end) begin
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        left_q  <= left_q - NB_W'(1);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign load_o     = go_data;
  assign line_o     = busy_q ? shreg_q[0] : 1'b1;
  assign busy_o     = busy_q;
  assign filling_o  = filling_q;
  assign sync_sel_o = sel_q;

  assert_line_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> $past(fall_i));

  assert_slot_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < cur_len));

  assert_fill_on_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filling_q) |-> !$past(hold_full_i));
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txc_i,
  input  logic              sync_mode_i,
  input  logic [1:0]        char_len_i,
  input  logic              parity_en_i,
  input  logic              parity_even_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        baud_sel_i,
  input  logic              sync_dual_i,
  input  logic [DATA_W-1:0] sync_char1_i,
  input  logic [DATA_W-1:0] sync_char2_i,
  input  logic              tx_en_i,
  input  logic              cts_ni,
  input  logic              break_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              txrdy_o,
  output logic              txrdy_stat_o,
  output logic              txempty_o
);
  logic              fall, load, line, busy, filling, sync_sel, enable;
  logic              hold_full_q;
  logic [DATA_W-1:0] hold_q, sync_char;
  frame_t            data_frame, sync_frame;

  assign enable    = tx_en_i & ~cts_ni;
  assign sync_char = sync_sel ? sync_char2_i : sync_char1_i;

  dbtx_clk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .txc_i(txc_i), .fall_o(fall)
  );

  dbtx_framer u_data_framer (
    .data_i(hold_q), .char_len_i(char_len_i), .parity_en_i(parity_en_i),
    .parity_even_i(parity_even_i), .sync_mode_i(sync_mode_i),
    .stop_sel_i(stop_sel_i), .baud_sel_i(baud_sel_i), .frame_o(data_frame)
  );

  dbtx_framer u_sync_framer (
    .data_i(sync_char), .char_len_i(char_len_i), .parity_en_i(parity_en_i),
    .parity_even_i(parity_even_i), .sync_mode_i(1'b1),
    .stop_sel_i(stop_sel_i), .baud_sel_i(baud_sel_i), .frame_o(sync_frame)
  );

  dbtx_engine u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .enable_i(enable),
    .sync_mode_i(sync_mode_i), .sync_dual_i(sync_dual_i),
    .hold_full_i(hold_full_q), .data_frame_i(data_frame),
    .sync_frame_i(sync_frame), .load_o(load), .line_o(line), .busy_o(busy),
    .filling_o(filling), .sync_sel_o(sync_sel)
  );

  // a write in the same cycle as a load refills the register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (wr_i) begin
      hold_q      <= wr_data_i;
      hold_full_q <= 1'b1;
    end else if (load) begin
      hold_full_q <= 1'b0;
    end
  end

  assign txrdy_stat_o = ~hold_full_q;
  assign txrdy_o      = ~hold_full_q & enable;
  assign txempty_o    = ~hold_full_q & (~busy | filling);
  assign txd_o        = break_i ? 1'b0 : line;

  assert_wr_clears_rdy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!txrdy_stat_o && !txrdy_o));

  assert_wr_clears_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !txempty_o);

  assert_held_while_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txrdy_stat_o && !(tx_en_i && !cts_ni)) |=> !txrdy_stat_o);
endmodule

// File: tb/dbuf_serial_tx_tb.sv
module dbuf_serial_tx_tb;
  logic       clk = 0, txc = 0, rst_n = 0;
  logic       sync_mode = 0, parity_en = 0, parity_even = 0, sync_dual = 0;
  logic [1:0] char_len = 2'd3, stop_sel = 2'b01, baud_sel = 2'b10;
  logic [7:0] sync1 = 8'h16, sync2 = 8'h2C, wr_data = 0;
  logic       tx_en = 0, cts_n = 0, brk = 0, wr = 0;
  logic       txd, txrdy, txrdy_stat, txempty;

  always #4 clk = ~clk;      // 125 MHz
  always #128 txc = ~txc;    // 32 system clocks per transmit clock

  dbuf_serial_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .txc_i(txc), .sync_mode_i(sync_mode),
    .char_len_i(char_len), .parity_en_i(parity_en), .parity_even_i(parity_even),
    .stop_sel_i(stop_sel), .baud_sel_i(baud_sel), .sync_dual_i(sync_dual),
    .sync_char1_i(sync1), .sync_char2_i(sync2), .tx_en_i(tx_en), .cts_ni(cts_n),
    .break_i(brk), .wr_i(wr), .wr_data_i(wr_data), .txd_o(txd), .txrdy_o(txrdy),
    .txrdy_stat_o(txrdy_stat), .txempty_o(txempty)
  );

  typedef struct {int data; int nd; bit pen; bit peven; int fac; int nstop;} exp_t;
  exp_t expq[$];
  bit   bitq[$];
  int   total = 0, bad = 0, cyc = 0, frames_seen = 0, prev_start = 0, last_gap = 0;
  bit   mon_on = 0, cap_on = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(0, "watchdog", cyc, 190000);
      summary();
      $finish;
    end
  end

  // monitor: decodes asynchronous frames and compares with the scoreboard
  exp_t m_e;
  int   m_got, m_bit;
  bit   m_ok, m_par;
  initial forever begin
    @(negedge clk);
    if (mon_on && rst_n && txd === 1'b0) begin
      last_gap   = cyc - prev_start;
      prev_start = cyc;
      if (expq.size() == 0) begin
        check(0, "R8 unexpected frame", 0, 1);
        while (txd === 1'b0) @(negedge clk);
      end else begin
        m_e   = expq.pop_front();
        m_bit = m_e.fac * 32;
        repeat (m_bit / 2) @(negedge clk);
        m_ok  = (txd == 1'b0);
        m_got = 0;
        for (int k = 0; k < m_e.nd; k++) begin
          repeat (m_bit) @(negedge clk);
          m_got = m_got | (int'(txd) << k);
        end
        check(m_got == m_e.data, "R9 data lsb first", m_got, m_e.data);
        if (m_e.pen) begin
          repeat (m_bit) @(negedge clk);
          m_par = m_e.peven ? ^m_e.data : ~(^m_e.data);
          check(txd == m_par, "R9 parity", int'(txd), int'(m_par));
        end
        repeat (m_bit) @(negedge clk);
        m_ok = m_ok && (txd == 1'b1);
        if (m_e.nstop == 4) begin
          repeat (m_bit) @(negedge clk);
          m_ok = m_ok && (txd == 1'b1);
        end
        check(m_ok, "R8 start and stop levels", int'(m_ok), 1);
        frames_seen++;
      end
    end
  end

  initial forever begin
    @(posedge txc);
    if (cap_on) bitq.push_back(txd);
  end

  task automatic set_cfg(input logic [1:0] len, input bit pen, input bit peven,
                         input logic [1:0] baud, input logic [1:0] stop);
    char_len = len; parity_en = pen; parity_even = peven; baud_sel = baud; stop_sel = stop;
  endtask

  // driver: pushes the expected frame, then writes
  task automatic send(input logic [7:0] d, input bit expect_out);
    exp_t e;
    while (!txrdy_stat) @(negedge clk);
    if (expect_out) begin
      e.nd    = 5 + int'(char_len);
      e.data  = int'(d) & ((1 << e.nd) - 1);
      e.pen   = parity_en;
      e.peven = parity_even;
      e.fac   = (baud_sel == 2'b10) ? 16 : (baud_sel == 2'b11) ? 64 : 1;
      e.nstop = (stop_sel == 2'b10) ? 3 : (stop_sel == 2'b11) ? 4 : 2;
      expq.push_back(e);
    end
    wr = 1; wr_data = d;
    @(negedge clk);
    wr = 0;
    check(!txrdy_stat && !txrdy && !txempty, "R1 R3 write clears flags",
          {txrdy_stat, txrdy, txempty}, 0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(txempty && expq.size() == 0));
    repeat (40) @(negedge clk);
  endtask

  task automatic gap_pair(input logic [7:0] a, input logic [7:0] b, input int exp_gap,
                          input string req);
    int base;
    base = frames_seen;
    send(a, 1);
    send(b, 1);
    while (frames_seen < base + 2) @(negedge clk);
    check(last_gap == exp_gap, req, last_gap, exp_gap);
    wait_idle();
  endtask

  task automatic check_stream(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                              input logic [7:0] b3, input int n, input string req);
    logic [7:0] exps [4];
    logic [7:0] got;
    int idx;
    exps[0] = b0; exps[1] = b1; exps[2] = b2; exps[3] = b3;
    idx = 0;
    while (idx < bitq.size() && bitq[idx] == 1'b1) idx++;
    for (int b = 0; b < n; b++) begin
      got = '0;
      for (int k = 0; k < 8; k++) begin
        if (idx < bitq.size()) got[k] = bitq[idx];
        idx++;
      end
      check(got == exps[b], req, got, exps[b]);
    end
  endtask

  initial begin
    int lows, base;
    repeat (5) @(negedge clk);
    check(txd && txrdy_stat && txempty && !txrdy, "R2 R3 R1 reset state",
          {txd, txrdy_stat, txempty, txrdy}, 4'b1110);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tx_en = 1;
    @(negedge clk);
    check(txrdy == 1'b1, "R1 ready pin when enabled", txrdy, 1);
    cts_n = 1;
    @(negedge clk);
    check(!txrdy && txrdy_stat, "R1 pin gated by cts, status not", {txrdy, txrdy_stat}, 2'b01);
    cts_n = 0;
    mon_on = 1;

    set_cfg(2'd3, 0, 0, 2'b10, 2'b01);
    gap_pair(8'h5A, 8'hC3, 10 * 16 * 32, "R8 R7 one stop x16 frame length");
    set_cfg(2'd3, 0, 0, 2'b10, 2'b10);
    gap_pair(8'h0F, 8'hF0, 21 * 8 * 32, "R8 one and a half stop length");
    set_cfg(2'd2, 1, 1, 2'b10, 2'b11);
    gap_pair(8'hFF, 8'h80, 11 * 16 * 32, "R8 R9 seven bits even parity two stops");
    set_cfg(2'd0, 1, 0, 2'b01, 2'b01);
    gap_pair(8'h13, 8'hEC, 8 * 32, "R7 R9 five bits odd parity x1");
    set_cfg(2'd3, 0, 0, 2'b11, 2'b01);
    gap_pair(8'hA7, 8'h31, 10 * 64 * 32, "R7 x64 frame length");

    // R6: held while clear-to-send is high
    set_cfg(2'd3, 0, 0, 2'b01, 2'b01);
    base  = frames_seen;
    cts_n = 1;
    send(8'h4E, 1);
    lows = 0;
    repeat (2000) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    check(lows == 0 && !txrdy_stat && !txempty, "R6 gated character not sent", lows, 0);
    cts_n = 0;
    wait_idle();
    check(frames_seen == base + 1, "R6 character sent after enable", frames_seen - base, 1);

    // R5: disable mid-frame
    set_cfg(2'd3, 0, 0, 2'b10, 2'b01);
    base = frames_seen;
    send(8'h96, 1);
    while (!(txrdy_stat && !txempty)) @(negedge clk);
    repeat (100) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    check(!txrdy && txrdy_stat, "R1 pin low when disabled", {txrdy, txrdy_stat}, 2'b01);
    repeat (12 * 512) @(negedge clk);
    check(txd && txempty, "R5 line and empty high after finishing", {txd, txempty}, 2'b11);
    check(frames_seen == base + 1, "R5 started character completed", frames_seen - base, 1);
    tx_en = 1;

    // R2: break
    mon_on = 0;
    brk = 1;
    @(negedge clk);
    check(txd == 1'b0, "R2 break forces low", txd, 0);
    brk = 0;
    @(negedge clk);
    check(txd == 1'b1, "R2 mark after break", txd, 1);

    // R4 R10: synchronous mode, single sync character
    set_cfg(2'd3, 0, 0, 2'b10, 2'b01);
    sync_mode = 1; sync_dual = 0;
    repeat (64) @(negedge clk);
    bitq.delete();
    cap_on = 1;
    send(8'h5A, 0);
    repeat (30 * 32) @(negedge clk);
    check(txempty == 1'b1, "R3 empty high during sync fill", txempty, 1);
    cap_on = 0;
    check_stream(8'h5A, 8'h16, 8'h16, 8'h00, 3, "R10 R4 raw data then sync fill");
    tx_en = 0;
    repeat (20 * 32) @(negedge clk);
    check(txd && txempty, "R5 sync fill stops when disabled", {txd, txempty}, 2'b11);

    // R4: two sync characters alternate
    tx_en = 1; sync_dual = 1;
    bitq.delete();
    cap_on = 1;
    send(8'h3C, 0);
    repeat (40 * 32) @(negedge clk);
    cap_on = 0;
    check_stream(8'h3C, 8'h16, 8'h2C, 8'h16, 4, "R4 alternating sync characters");

    check(expq.size() == 0, "R8 every expected frame seen", expq.size(), 0);
    summary();
    $finish;
  end
endmodule